// File: doc/BRIEF.md
# Constrained Minimum-Power Configuration Selector

The selector holds a table of candidate operating points. Each entry pairs a configuration identifier with a clock frequency code and three measured figures: power, throughput and accuracy. When a selection is requested, the block walks the table one entry per cycle. It keeps only the entries that reach the requested throughput and accuracy floors and tracks the one that draws the least power. At the end of the walk it reports that entry's configuration and frequency code.

An optional power ceiling is applied afterwards to the winner alone. If the lowest-power qualifying entry is above the ceiling, or no entry qualifies, the block raises a no-solution flag and keeps the last good selection on its outputs. A new walk starts on a start strobe, or by itself when any constraint input differs from the values used by the previous walk. The table and its active length are loaded through a simple write port.

Top module: `cfg_selector`

## Requirements
- R1: An entry qualifies only if its throughput is greater than or equal to the throughput floor and its accuracy is greater than or equal to the accuracy floor. Both comparisons are inclusive.
- R2: Among the qualifying entries, the one with the smallest power is selected. `cfg_o` and `freq_o` take that entry's own configuration and frequency fields, even when the same configuration is stored with several frequencies.
- R3: When qualifying entries have equal lowest power, the one at the lower table index is selected.
- R4: With `pwr_cap_en_i` high, a winner whose power is above `pwr_cap_i` gives no solution. A winner whose power equals the ceiling is accepted. With the enable low, the ceiling has no effect.
- R5: When no solution exists, `no_sol_o` goes to 1, `valid_o` goes to 0, and `cfg_o` and `freq_o` keep their previous values. `valid_o` and `no_sol_o` are never both 1.
- R6: Let E0 be the clock edge at which a walk is accepted and L the table length. The outputs change at edge E0+L and not before. With L = 0, the outputs report no solution at E0 itself.
- R7: A walk is accepted at a clock edge while the block is idle if `start_i` is high, or if any of `min_thr_i`, `min_acc_i`, `pwr_cap_i` or `pwr_cap_en_i` differs from the value latched at the previous acceptance. When idle and without such a trigger, the outputs hold.
- R8: Only indices below the table length take part in a walk. A length write above N_ENTRIES is stored as N_ENTRIES. A length write made while a walk is running is ignored.
- R9: After reset, `cfg_o` = 0, `freq_o` = 0, `valid_o` = 0, `no_sol_o` = 0, and the table length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table entry |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_cfg_i | input | CFG_W | Configuration identifier |
| wr_freq_i | input | FREQ_W | Frequency code |
| wr_pwr_i | input | PWR_W | Power figure |
| wr_thr_i | input | THR_W | Throughput figure |
| wr_acc_i | input | ACC_W | Accuracy figure |
| len_we_i | input | 1 | Write table length |
| len_i | input | LEN_W | New table length |
| start_i | input | 1 | Request a walk |
| min_thr_i | input | THR_W | Throughput floor |
| min_acc_i | input | ACC_W | Accuracy floor |
| pwr_cap_i | input | PWR_W | Power ceiling |
| pwr_cap_en_i | input | 1 | Apply power ceiling |
| cfg_o | output | CFG_W | Selected configuration |
| freq_o | output | FREQ_W | Selected frequency code |
| valid_o | output | 1 | Last walk found a solution |
| no_sol_o | output | 1 | Last walk found no solution |

## Verification
The bench sets up entries whose figures sit exactly on the floors, and two entries with equal power. A design with strict comparisons would drop the boundary entry. A design that replaces the winner on equal power would report the higher index. The ceiling is tested one below and exactly at the winner's power, to catch an off-by-one in the ceiling test. No-solution cases confirm that the last good configuration stays on the outputs and is not cleared or overwritten. The bench samples one cycle before each expected result as well as at it, so a walk that ends early or late shows up. It also checks a change of length made during a walk, a length above the table size, an empty table, and a trigger caused only by a changed constraint.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;
endpackage

// File: rtl/cfg_table.sv
module cfg_table #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 4,
  parameter int CFG_W     = 4,
  parameter int FREQ_W    = 3,
  parameter int PWR_W     = 12,
  parameter int THR_W     = 12,
  parameter int ACC_W     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CFG_W-1:0]  wr_cfg_i,
  input  logic [FREQ_W-1:0] wr_freq_i,
  input  logic [PWR_W-1:0]  wr_pwr_i,
  input  logic [THR_W-1:0]  wr_thr_i,
  input  logic [ACC_W-1:0]  wr_acc_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CFG_W-1:0]  rd_cfg_o,
  output logic [FREQ_W-1:0] rd_freq_o,
  output logic [PWR_W-1:0]  rd_pwr_o,
  output logic [THR_W-1:0]  rd_thr_o,
  output logic [ACC_W-1:0]  rd_acc_o
);
  logic [CFG_W-1:0]  cfg_q  [N_ENTRIES];
  logic [FREQ_W-1:0] freq_q [N_ENTRIES];
  logic [PWR_W-1:0]  pwr_q  [N_ENTRIES];
  logic [THR_W-1:0]  thr_q  [N_ENTRIES];
  logic [ACC_W-1:0]  acc_q  [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g]  <= '0;
        freq_q[g] <= '0;
        pwr_q[g]  <= '0;
        thr_q[g]  <= '0;
        acc_q[g]  <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        cfg_q[g]  <= wr_cfg_i;
        freq_q[g] <= wr_freq_i;
        pwr_q[g]  <= wr_pwr_i;
        thr_q[g]  <= wr_thr_i;
        acc_q[g]  <= wr_acc_i;
      end
    end
  end

  assign rd_cfg_o  = cfg_q[rd_idx_i];
  assign rd_freq_o = freq_q[rd_idx_i];
  assign rd_pwr_o  = pwr_q[rd_idx_i];
  assign rd_thr_o  = thr_q[rd_idx_i];
  assign rd_acc_o  = acc_q[rd_idx_i];
endmodule

// File: rtl/elig_filter.sv
module elig_filter #(
  parameter int THR_W = 12,
  parameter int ACC_W = 10
) (
  input  logic             active_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [THR_W-1:0] min_thr_i,
  input  logic [ACC_W-1:0] min_acc_i,
  output logic             elig_o
);
  // floors are inclusive
  assign elig_o = active_i && (thr_i >= min_thr_i) && (acc_i >= min_acc_i);
endmodule

// File: rtl/min_tracker.sv
module min_tracker #(
  parameter int IDX_W = 4,
  parameter int PWR_W = 12,
  parameter int PAY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cand_vld_i,
  input  logic [IDX_W-1:0] cand_idx_i,
  input  logic [PWR_W-1:0] cand_pwr_i,
  input  logic [PAY_W-1:0] cand_pay_i,
  output logic             nxt_found_o,
  output logic [PWR_W-1:0] nxt_pwr_o,
  output logic [PAY_W-1:0] nxt_pay_o
);
  logic             found_q;
  logic [IDX_W-1:0] best_idx_q, nxt_idx;
  logic [PWR_W-1:0] best_pwr_q;
  logic [PAY_W-1:0] best_pay_q;
  logic             take;

  // strict compare keeps the earlier index on equal power
  assign take        = cand_vld_i && (!found_q || cand_pwr_i < best_pwr_q);
  assign nxt_found_o = found_q || cand_vld_i;
  assign nxt_idx     = take ? cand_idx_i : best_idx_q;
  assign nxt_pwr_o   = take ? cand_pwr_i : best_pwr_q;
  assign nxt_pay_o   = take ? cand_pay_i : best_pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q    <= 1'b0;
      best_idx_q <= '0;
      best_pwr_q <= '0;
      best_pay_q <= '0;
    end else if (clr_i) begin
      found_q    <= 1'b0;
    end else begin
      found_q    <= nxt_found_o;
      best_idx_q <= nxt_idx;
      best_pwr_q <= nxt_pwr_o;
      best_pay_q <= nxt_pay_o;
    end
  end

  assert_tie_keeps_lower_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q && !clr_i && cand_vld_i && cand_pwr_i == best_pwr_q |=> $stable(best_idx_q));

  assert_running_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q && !clr_i |=> found_q && best_pwr_q <= $past(best_pwr_q));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import cfg_sel_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             accept_o,
  output logic             scan_o,
  output logic             last_o,
  output logic             empty_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [LEN_W-1:0] LenMax = LEN_W'(N_ENTRIES);

  scan_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;

  assign scan_o   = (st_q == ST_SCAN);
  assign accept_o = (st_q == ST_IDLE) && trig_i;
  assign empty_o  = accept_o && (len_q == '0);
  assign last_o   = scan_o && (LEN_W'(idx_q) + LEN_W'(1) >= len_q);
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (accept_o && !empty_o) begin
      st_q  <= ST_SCAN;
      idx_q <= '0;
    end else if (last_o) begin
      st_q  <= ST_IDLE;
    end else if (scan_o) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  // length is frozen during a walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (len_we_i && !scan_o) len_q <= (len_i > LenMax) ? LenMax : len_i;
  end

  assert_idx_in_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_o |-> LEN_W'(idx_q) < len_q);

  assert_len_clamped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LenMax);

  assert_scan_starts_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && len_q != '0 |=> scan_o && idx_q == '0);

  assert_len_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_o |=> $stable(len_q));
endmodule

// File: rtl/cfg_selector.sv
module cfg_selector
  import cfg_sel_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CFG_W     = 4,
  parameter int FREQ_W    = 3,
  parameter int PWR_W     = 12,
  parameter int THR_W     = 12,
  parameter int ACC_W     = 10,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  parameter int LEN_W     = $clog2(N_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CFG_W-1:0]  wr_cfg_i,
  input  logic [FREQ_W-1:0] wr_freq_i,
  input  logic [PWR_W-1:0]  wr_pwr_i,
  input  logic [THR_W-1:0]  wr_thr_i,
  input  logic [ACC_W-1:0]  wr_acc_i,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              start_i,
  input  logic [THR_W-1:0]  min_thr_i,
  input  logic [ACC_W-1:0]  min_acc_i,
  input  logic [PWR_W-1:0]  pwr_cap_i,
  input  logic              pwr_cap_en_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              valid_o,
  output logic              no_sol_o
);
  localparam int PAY_W = CFG_W + FREQ_W;

  logic [THR_W-1:0]  thr_q;
  logic [ACC_W-1:0]  acc_q;
  logic [PWR_W-1:0]  cap_q;
  logic              cap_en_q;
  logic              trig, accept, scan, last, empty, elig, fin, ok, done_q;
  logic [IDX_W-1:0]  idx;
  logic [CFG_W-1:0]  rd_cfg;
  logic [FREQ_W-1:0] rd_freq;
  logic [PWR_W-1:0]  rd_pwr, nxt_pwr, sel_pwr_q;
  logic [THR_W-1:0]  rd_thr;
  logic [ACC_W-1:0]  rd_acc;
  logic              nxt_found;
  logic [PAY_W-1:0]  nxt_pay;

  assign trig = start_i || (min_thr_i != thr_q) || (min_acc_i != acc_q) ||
                (pwr_cap_i != cap_q) || (pwr_cap_en_i != cap_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q    <= '0;
      acc_q    <= '0;
      cap_q    <= '0;
      cap_en_q <= 1'b0;
    end else if (accept) begin
      thr_q    <= min_thr_i;
      acc_q    <= min_acc_i;
      cap_q    <= pwr_cap_i;
      cap_en_q <= pwr_cap_en_i;
    end
  end

  scan_ctrl #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .LEN_W(LEN_W)) i_scan_ctrl (
    .clk_i, .rst_ni, .trig_i(trig), .len_we_i, .len_i,
    .accept_o(accept), .scan_o(scan), .last_o(last), .empty_o(empty), .idx_o(idx)
  );

  cfg_table #(
    .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .CFG_W(CFG_W), .FREQ_W(FREQ_W),
    .PWR_W(PWR_W), .THR_W(THR_W), .ACC_W(ACC_W)
  ) i_cfg_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_cfg_i, .wr_freq_i, .wr_pwr_i,
    .wr_thr_i, .wr_acc_i, .rd_idx_i(idx), .rd_cfg_o(rd_cfg), .rd_freq_o(rd_freq),
    .rd_pwr_o(rd_pwr), .rd_thr_o(rd_thr), .rd_acc_o(rd_acc)
  );

  elig_filter #(.THR_W(THR_W), .ACC_W(ACC_W)) i_elig_filter (
    .active_i(scan), .thr_i(rd_thr), .acc_i(rd_acc),
    .min_thr_i(thr_q), .min_acc_i(acc_q), .elig_o(elig)
  );

  min_tracker #(.IDX_W(IDX_W), .PWR_W(PWR_W), .PAY_W(PAY_W)) i_min_tracker (
    .clk_i, .rst_ni, .clr_i(accept), .cand_vld_i(elig), .cand_idx_i(idx),
    .cand_pwr_i(rd_pwr), .cand_pay_i({rd_cfg, rd_freq}),
    .nxt_found_o(nxt_found), .nxt_pwr_o(nxt_pwr), .nxt_pay_o(nxt_pay)
  );

  // ceiling applies to the winner only
  assign fin = last || empty;
  assign ok  = last && nxt_found && (!cap_en_q || nxt_pwr <= cap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      freq_o    <= '0;
      sel_pwr_q <= '0;
      valid_o   <= 1'b0;
      no_sol_o  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        valid_o  <= ok;
        no_sol_o <= !ok;
        if (ok) begin
          {cfg_o, freq_o} <= nxt_pay;
          sel_pwr_q       <= nxt_pwr;
        end
      end
    end
  end

  assert_flags_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && no_sol_o));

  assert_under_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && valid_o && cap_en_q |-> sel_pwr_q <= cap_q);

  assert_hold_on_nosol_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_sol_o) |-> $stable(cfg_o) && $stable(freq_o));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan && !accept |=> $stable(cfg_o) && $stable(freq_o) && $stable(valid_o));
endmodule

// File: tb/test_cfg_selector.sv
module test_cfg_selector;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [3:0]  wr_cfg = '0;
  logic [2:0]  wr_freq = '0;
  logic [11:0] wr_pwr = '0;
  logic [11:0] wr_thr = '0;
  logic [9:0]  wr_acc = '0;
  logic        len_we = 1'b0;
  logic [4:0]  len_v = '0;
  logic        start = 1'b0;
  logic [11:0] min_thr = '0;
  logic [9:0]  min_acc = '0;
  logic [11:0] cap = '0;
  logic        cap_en = 1'b0;
  logic [3:0]  cfg_o;
  logic [2:0]  freq_o;
  logic        valid_o, no_sol_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_selector i_cfg_selector (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_cfg_i(wr_cfg),
    .wr_freq_i(wr_freq), .wr_pwr_i(wr_pwr), .wr_thr_i(wr_thr), .wr_acc_i(wr_acc),
    .len_we_i(len_we), .len_i(len_v), .start_i(start), .min_thr_i(min_thr),
    .min_acc_i(min_acc), .pwr_cap_i(cap), .pwr_cap_en_i(cap_en),
    .cfg_o, .freq_o, .valid_o, .no_sol_o
  );

  typedef struct { int cyc; int val; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // reference table
  int m_cfg[N], m_freq[N], m_pwr[N], m_thr[N], m_acc[N];
  int m_len = 0;
  int e_cfg = 0, e_freq = 0, e_v = 0, e_ns = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pack_out(int c, int f, int v, int ns);
    return (c << 5) | (f << 2) | (v << 1) | ns;
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      if (exp_q[0].cyc < cyc) chk({exp_q[0].tag, " missed"}, -1, exp_q[0].val);
      else chk(exp_q[0].tag, pack_out(int'(cfg_o), int'(freq_o), int'(valid_o), int'(no_sol_o)),
               exp_q[0].val);
      void'(exp_q.pop_front());
    end
  end

  task automatic wr_ent(int i, int c, int f, int p, int t, int a);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(i); wr_cfg = 4'(c); wr_freq = 3'(f);
    wr_pwr = 12'(p); wr_thr = 12'(t); wr_acc = 10'(a);
    m_cfg[i] = c; m_freq[i] = f; m_pwr[i] = p; m_thr[i] = t; m_acc[i] = a;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_len(int v);
    @(negedge clk);
    len_we = 1; len_v = 5'(v);
    m_len = (v > N) ? N : v;
    @(negedge clk);
    len_we = 0;
  endtask

  // driver: applies constraints, pushes expected outputs one cycle early and on time
  task automatic run(bit do_start, int t, int a, int cp, bit ce, int inj_len, string tag);
    int best, c0;
    bit ok;
    @(negedge clk);
    start = do_start; min_thr = 12'(t); min_acc = 10'(a); cap = 12'(cp); cap_en = ce;
    c0 = cyc + 1;
    if (m_len > 0)
      exp_q.push_back('{c0 + m_len - 1, pack_out(e_cfg, e_freq, e_v, e_ns), {tag, " early"}});
    best = -1;
    for (int i = 0; i < m_len; i++)
      if (m_thr[i] >= t && m_acc[i] >= a)
        if (best < 0 || m_pwr[i] < m_pwr[best]) best = i;
    ok = (best >= 0) && (!ce || m_pwr[best] <= cp);
    if (ok) begin e_cfg = m_cfg[best]; e_freq = m_freq[best]; e_v = 1; e_ns = 0; end
    else begin e_v = 0; e_ns = 1; end
    exp_q.push_back('{c0 + m_len, pack_out(e_cfg, e_freq, e_v, e_ns), tag});
    @(negedge clk);
    start = 0;
    if (inj_len >= 0) begin
      len_we = 1; len_v = 5'(inj_len);
      @(negedge clk);
      len_we = 0;
    end
    repeat (m_len + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R9 reset outputs", pack_out(int'(cfg_o), int'(freq_o), int'(valid_o), int'(no_sol_o)), 0);
    wr_ent(0, 1, 0, 500, 100, 40);
    wr_ent(1, 1, 1, 300, 60, 40);
    wr_ent(2, 2, 0, 200, 30, 20);
    wr_ent(3, 3, 2, 200, 80, 35);
    wr_ent(4, 4, 1, 450, 120, 50);
    wr_ent(5, 5, 3, 250, 90, 30);
    wr_ent(6, 6, 0, 700, 150, 60);
    wr_ent(7, 7, 4, 150, 20, 10);
    for (int i = 8; i < N; i++) begin m_cfg[i] = 0; m_freq[i] = 0; m_pwr[i] = 0; m_thr[i] = 0; m_acc[i] = 0; end
    wr_ent(10, 9, 5, 50, 200, 63);
    set_len(8);
    run(1, 0, 0, 0, 0, -1, "R2 min power no floors");
    run(1, 30, 20, 0, 0, -1, "R3 tie lower index, R1 floor equal");
    run(1, 31, 20, 0, 0, -1, "R1 floor one above");
    run(0, 80, 35, 0, 0, -1, "R7 auto trigger on floor change");
    run(0, 80, 35, 199, 1, -1, "R4 winner above ceiling");
    run(0, 80, 35, 200, 1, -1, "R4 winner at ceiling");
    run(1, 80, 35, 200, 1, 2, "R7 start unchanged, R8 len write during walk");
    run(1, 80, 35, 200, 1, -1, "R8 length kept after ignored write, R6");
    run(0, 160, 35, 200, 1, -1, "R5 no eligible holds output");
    run(0, 60, 40, 200, 0, -1, "R2 frequency variant of same cfg");
    run(0, 100, 0, 200, 0, -1, "R8 length limits walk");
    set_len(20);
    run(1, 100, 0, 200, 0, -1, "R8 length clamped to table size");
    set_len(0);
    run(1, 100, 0, 200, 0, -1, "R6 empty table");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk("R6 pending results", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule